// File: doc/BRIEF.md
# Coherency Unit Control Registers

This block is the register file that software uses to steer a multicore cache-coherency unit. A small synchronous bus port carries an 8-bit offset into a 256-byte window, a byte count for the access, write data and a read strobe. The block holds three things: a one-bit enable, a read-only configuration word built from the core count, and a 32-bit power-status word. The power-status word can be written a byte lane at a time.

Every other offset in the window reads as zero and ignores writes. This covers the invalidate-all trigger, the filter address pair, the access-control pair, and any unassigned offset. Two resets are provided. Cold reset clears all state. Warm reset clears only the enable, so the power-status word survives it. The core count is a parameter from 1 to 4.

Top module: `scu_ctrl_regs`

## Requirements
- R1: Offset 0x00 is the enable register. A write of any valid size stores only `wdata_i[0]`, and a read returns that bit in bit 0 with bits 31:1 zero.
- R2: The enable register is cleared to 0 by either `rst_ni` (cold) or `warm_rst_ni` (warm).
- R3: Offset 0x04 reads `((1<<NUM_CPU)-1)<<4 | (NUM_CPU-1)`. A write to it changes no state.
- R4: A write at offset 0x08+k (k = 0..3) with byte count n replaces status bits `[8k +: 8n]` with the low `8n` bits of write data. Bits above bit 31 are discarded, and all other status bits are kept.
- R5: A read at offset 0x08+k returns the status word shifted right by `8k`, with zeros filled in at the top and no lane mask applied.
- R6: `size_i` holds the byte count of the access, and only the values 1, 2 and 4 are valid. A write with any other value changes neither the enable nor the status.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other offset not named in R1, R3 or R4 read as zero, and writes to them change no state.
- R8: Cold reset sets the status word to zero. Warm reset leaves it unchanged.
- R9: `rdata_o` is registered. It takes the value addressed in the cycle where `rd_en_i` is high, is visible after that clock edge, and holds while `rd_en_i` is low. A read in the same cycle as a write returns the contents from before the write. `rdata_o` is zero after cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, asynchronous, active low |
| warm_rst_ni | input | 1 | Warm reset, asynchronous, active low; clears the enable only |
| addr_i | input | 8 | Byte offset within the window |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| size_i | input | 3 | Access byte count (1, 2 or 4 valid) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume that the bus inputs are defined and steady at each rising clock edge. They also assume that warm reset does not pulse between an access and the cycle in which it is checked; the properties are disabled while either reset is low. The stimulus changes every input on the falling edge and releases resets on a falling edge, so these assumptions always hold. A bench model computes the expected status arithmetically and checks it against sweeps over all 256 offsets, every lane offset, and every valid and invalid byte count.

// File: rtl/scu_ctrl_pkg.sv
package scu_ctrl_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CFG,
    SEL_STATUS
  } reg_sel_e;

  function automatic logic size_ok(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/scu_ctrl_decode.sv
module scu_ctrl_decode
  import scu_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output reg_sel_e          sel_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              size_ok_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == OFF_CTRL) sel_o = SEL_CTRL;
    else if (addr_i == OFF_CFG) sel_o = SEL_CFG;
    else if (addr_i[ADDR_W-1:LANE_W] == OFF_STATUS[ADDR_W-1:LANE_W]) sel_o = SEL_STATUS;
  end

  assign lane_o    = addr_i[LANE_W-1:0];
  assign size_ok_o = size_ok(size_i);
endmodule

// File: rtl/scu_ctrl_status.sv
module scu_ctrl_status
  import scu_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] wshift;
  assign wshift = wdata_i << (8 * lane_i);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic hit;
    // lane j lies in [lane, lane+size) and inside the word
    assign hit = we_i && (j >= int'(lane_i)) && ((j - int'(lane_i)) < int'(size_i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  status_o[8*j +: 8] <= '0;
      else if (hit) status_o[8*j +: 8] <= wshift[8*j +: 8];
    end
  end
endmodule

// File: rtl/scu_ctrl_rdmux.sv
module scu_ctrl_rdmux
  import scu_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CPU = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  reg_sel_e          sel_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] CPU_MASK = DATA_W'((1 << NUM_CPU) - 1);
  localparam logic [DATA_W-1:0] CFG_WORD = (CPU_MASK << 4) | DATA_W'(NUM_CPU - 1);

  logic [DATA_W-1:0] rd_d;
  always_comb begin
    unique case (sel_i)
      SEL_CTRL:   rd_d = {{(DATA_W-1){1'b0}}, ctrl_i};
      SEL_CFG:    rd_d = CFG_WORD;
      SEL_STATUS: rd_d = status_i >> (8 * lane_i);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/scu_ctrl_regs.sv
module scu_ctrl_regs
  import scu_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CPU = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cfg
    initial $fatal(1, "NUM_CPU out of range 1..4");
  end

  reg_sel_e          sel;
  logic [LANE_W-1:0] lane;
  logic              sz_ok;
  logic              ctrl_q;
  logic [DATA_W-1:0] status_q;
  logic              ctrl_rst_n;

  scu_ctrl_decode u_dec (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .sel_o    (sel),
    .lane_o   (lane),
    .size_ok_o(sz_ok)
  );

  assign ctrl_rst_n = rst_ni & warm_rst_ni;
  always_ff @(posedge clk_i or negedge ctrl_rst_n) begin
    if (!ctrl_rst_n) ctrl_q <= 1'b0;
    else if (wr_en_i && sz_ok && sel == SEL_CTRL) ctrl_q <= wdata_i[0];
  end

  scu_ctrl_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && sz_ok && sel == SEL_STATUS),
    .lane_i  (lane),
    .size_i  (size_i),
    .wdata_i (wdata_i),
    .status_o(status_q)
  );

  scu_ctrl_rdmux #(.NUM_CPU(NUM_CPU)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .sel_i   (sel),
    .lane_i  (lane),
    .ctrl_i  (ctrl_q),
    .status_i(status_q),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/scu_ctrl_regs_chk.sv
module scu_ctrl_regs_chk
  import scu_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CPU = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              warm_rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ctrl_q,
  input logic [DATA_W-1:0] status_q
);
  localparam logic [DATA_W-1:0] EXP_CFG =
      DATA_W'((((1 << NUM_CPU) - 1) << 4) | (NUM_CPU - 1));

  logic mapped, status_off, bad_sz;
  assign status_off = (addr_i >= 8'h08) && (addr_i <= 8'h0B);
  assign mapped     = (addr_i == 8'h00) || (addr_i == 8'h04) || status_off;
  assign bad_sz     = !((size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4));

  AST_CTRL_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    rd_en_i && addr_i == 8'h00 |=> rdata_o[DATA_W-1:1] == '0); // R1
  AST_CFG_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    rd_en_i && addr_i == 8'h04 |=> rdata_o == EXP_CFG); // R3
  AST_BAD_SIZE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    wr_en_i && bad_sz |=> $stable(status_q) && $stable(ctrl_q)); // R6
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    rd_en_i && !mapped |=> rdata_o == '0); // R7
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    wr_en_i && !status_off |=> $stable(status_q)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R9
endmodule

bind scu_ctrl_regs scu_ctrl_regs_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .warm_rst_ni(warm_rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .size_i     (size_i),
  .rdata_o    (rdata_o),
  .ctrl_q     (ctrl_q),
  .status_q   (status_q)
);

// File: tb/tb_scu_ctrl_regs.sv
module tb_scu_ctrl_regs;
  localparam int unsigned NCPU = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_ni = 1'b1;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  size_i = 3'd4;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int errors = 0;
  int checks = 0;
  logic        m_ctrl = 1'b0;
  logic [31:0] m_st = '0;
  logic [31:0] rd;

  always #5 clk_i = ~clk_i;

  scu_ctrl_regs #(.NUM_CPU(NCPU)) dut (.*);

  function automatic logic [31:0] exp_cfg();
    return (((32'd1 << NCPU) - 32'd1) << 4) | (NCPU - 1);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a == 8'h00) return {31'd0, m_ctrl};
    if (a == 8'h04) return exp_cfg();
    if (a >= 8'h08 && a <= 8'h0B) return m_st >> (8 * (a - 8'h08));
    return 32'd0;
  endfunction

  function automatic logic [31:0] size_mask(input logic [2:0] s);
    case (s)
      3'd1: return 32'h0000_00FF;
      3'd2: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; size_i = s; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rdt(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  // bench model of a write
  task automatic model_wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    logic [31:0] m, sh;
    if (!(s == 3'd1 || s == 3'd2 || s == 3'd4)) return;
    m = size_mask(s);
    if (a == 8'h00) m_ctrl = d[0];
    else if (a >= 8'h08 && a <= 8'h0B) begin
      sh = 32'(8 * (a - 8'h08));
      m_st = (m_st & ~(m << sh)) | ((d & m) << sh);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 256; a++) begin
      rdt(8'(a), rd);
      chk(rd === exp_rd(8'(a)), req, rd, exp_rd(8'(a)));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state (R2, R8, R9)
    chk(rdata_o === 32'd0, "R9 reset rdata", rdata_o, 32'd0);
    rdt(8'h00, rd); chk(rd === 32'd0, "R2 ctrl after cold reset", rd, 32'd0);
    rdt(8'h08, rd); chk(rd === 32'd0, "R8 status after cold reset", rd, 32'd0);
    rdt(8'h04, rd); chk(rd === exp_cfg(), "R3 config word", rd, exp_cfg());

    // R1 enable register, all valid sizes
    wr(8'h00, 3'd4, 32'hFFFF_FFFF); model_wr(8'h00, 3'd4, 32'hFFFF_FFFF);
    rdt(8'h00, rd); chk(rd === 32'd1, "R1 ctrl keeps bit0", rd, 32'd1);
    wr(8'h00, 3'd1, 32'hFFFF_FFFE); model_wr(8'h00, 3'd1, 32'hFFFF_FFFE);
    rdt(8'h00, rd); chk(rd === 32'd0, "R1 ctrl cleared by write", rd, 32'd0);
    wr(8'h00, 3'd2, 32'h0000_0003); model_wr(8'h00, 3'd2, 32'h0000_0003);
    rdt(8'h00, rd); chk(rd === 32'd1, "R1 ctrl half write", rd, 32'd1);

    // R3 writes to config ignored
    wr(8'h04, 3'd4, 32'h0000_0000);
    rdt(8'h04, rd); chk(rd === exp_cfg(), "R3 config write ignored", rd, exp_cfg());

    // R4/R5 sweep over lane offset and size
    for (int k = 0; k < 4; k++) begin
      for (int si = 0; si < 3; si++) begin
        logic [2:0] s;
        s = (si == 0) ? 3'd1 : (si == 1) ? 3'd2 : 3'd4;
        wr(8'h08, 3'd4, 32'h5A5A_5A5A); model_wr(8'h08, 3'd4, 32'h5A5A_5A5A);
        d = 32'h1234_5678 ^ (32'(k) * 32'h1111_0000) ^ 32'(si * 32'h0303);
        wr(8'(8 + k), s, d); model_wr(8'(8 + k), s, d);
        for (int r = 0; r < 4; r++) begin
          rdt(8'(8 + r), rd);
          chk(rd === exp_rd(8'(8 + r)), (r == 0) ? "R4 lane write" : "R5 shifted read",
              rd, exp_rd(8'(8 + r)));
        end
      end
    end

    // R6 invalid sizes dropped
    wr(8'h08, 3'd4, 32'hC3A5_0F96); model_wr(8'h08, 3'd4, 32'hC3A5_0F96);
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 8; s++) begin
        if (s == 1 || s == 2 || s == 4) continue;
        wr(8'(8 + k), 3'(s), 32'hFFFF_FFFF);
      end
    end
    rdt(8'h08, rd); chk(rd === m_st, "R6 bad size status kept", rd, m_st);
    wr(8'h00, 3'd0, 32'h0); wr(8'h00, 3'd7, 32'h0);
    rdt(8'h00, rd); chk(rd === {31'd0, m_ctrl}, "R6 bad size ctrl kept", rd, {31'd0, m_ctrl});

    // R7 full window read sweep, then write every unmapped offset
    check_all("R7 window read");
    for (int a = 0; a < 256; a++) begin
      if (a == 0 || (a >= 8 && a <= 11)) continue;
      wr(8'(a), 3'd4, 32'hFFFF_FFFF);
    end
    rdt(8'h08, rd); chk(rd === m_st, "R7 unmapped writes status kept", rd, m_st);
    rdt(8'h00, rd); chk(rd === {31'd0, m_ctrl}, "R7 unmapped writes ctrl kept", rd, {31'd0, m_ctrl});
    rdt(8'h0C, rd); chk(rd === 32'd0, "R7 invalidate reads zero", rd, 32'd0);

    // R9 hold and read-during-write
    repeat (3) @(negedge clk_i);
    chk(rdata_o === 32'd0, "R9 rdata holds", rdata_o, 32'd0);
    d = m_st;
    @(negedge clk_i);
    addr_i = 8'h08; size_i = 3'd4; wdata_i = 32'h0BAD_F00D; wr_en_i = 1'b1; rd_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    model_wr(8'h08, 3'd4, 32'h0BAD_F00D);
    chk(rdata_o === d, "R9 read sees pre-write value", rdata_o, d);
    rdt(8'h08, rd); chk(rd === 32'h0BAD_F00D, "R9 next read sees write", rd, 32'h0BAD_F00D);

    // R2/R8 warm reset
    wr(8'h00, 3'd4, 32'h1); model_wr(8'h00, 3'd4, 32'h1);
    @(negedge clk_i); warm_rst_ni = 1'b0;
    @(negedge clk_i); warm_rst_ni = 1'b1;
    m_ctrl = 1'b0;
    rdt(8'h00, rd); chk(rd === 32'd0, "R2 warm reset clears ctrl", rd, 32'd0);
    rdt(8'h08, rd); chk(rd === m_st, "R8 warm reset keeps status", rd, m_st);

    // R2/R8 cold reset
    wr(8'h00, 3'd4, 32'h1);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    m_ctrl = 1'b0; m_st = '0;
    rdt(8'h00, rd); chk(rd === 32'd0, "R2 cold reset clears ctrl", rd, 32'd0);
    rdt(8'h08, rd); chk(rd === 32'd0, "R8 cold reset clears status", rd, 32'd0);
    check_all("R5 window after cold reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule